// File: doc/BRIEF.md
# Relocatable Vectored Interrupt Controller

This block gathers four active-low external request lines and a parameterised set of internal event requests. It records them as pending flags, picks one at a time by fixed priority, and turns the choice into the memory address of a vector-table slot. It then reads the handler start address stored in that slot through a simple read port and hands that word to the CPU together with a one-cycle valid pulse, which acts as the acknowledge.

External lines first pass through a two-flop synchroniser. A single mode input switches all four external lines between level sensing and edge sensing. In level sensing, a line that stays low keeps raising new requests, so it is serviced again and again. In edge sensing, a line must go from high to low and then stay low for two consecutive samples before one request is recorded. The table base is a software pointer shifted left by eight bits, so the table can sit on any 256-word boundary. Each source has a fixed slot offset from that base.

The fetch sequencer is a four-state machine. ST_IDLE moves to ST_FETCH when the global enable is high and some flag is pending; on that move it latches the winner and forms the slot address. ST_FETCH raises the read strobe and always moves to ST_CAPT. ST_CAPT takes in the returned word, clears the winner's flag and always moves to ST_DONE. ST_DONE raises the valid pulse and always returns to ST_IDLE.

Top module: `rvic_top`

## Requirements
- R1: After reset, `mem_rd` and `vec_valid` are low, and they stay low while no request arrives.
- R2: In level mode (`edge_mode`=0), a low level on `ext_req_n[k]` that is seen through the synchroniser leads to one vector fetch for source k.
- R3: In level mode, a line that is held low causes repeated, back-to-back services of the same source for as long as it stays low.
- R4: In edge mode (`edge_mode`=1), a low pulse on an external line that lasts only one sampled cycle is ignored, and no fetch follows.
- R5: In edge mode, a high-to-low transition followed by at least two consecutive low samples yields exactly one service, however long the line then stays low.
- R6: The fetch address is `{tbl_ptr, 8'h00}` plus the source offset. Offsets are 1 to 4 for `ext_req_n[0]` to `ext_req_n[3]` and 5 for `int_evt[0]`; for example, `tbl_ptr`=100h gives 10005h for `int_evt[0]`. `vec_id` carries that offset.
- R7: `vec_addr` equals the `mem_rdata` word returned in the cycle after the `mem_rd` strobe. `vec_valid` is a one-cycle pulse, two cycles after the strobe.
- R8: When several sources are pending, they are serviced in order of increasing offset.
- R9: While `glob_en` is low, no fetch starts and pending flags are kept. They are serviced once `glob_en` rises.
- R10: `mem_rd` is a one-cycle strobe, and there is exactly one strobe for each `vec_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 4 | External requests, active low, asynchronous |
| int_evt | input | NUM_INT | Internal event requests, active-high pulses, synchronous |
| edge_mode | input | 1 | 0 = level sensing, 1 = edge sensing for all external lines |
| glob_en | input | 1 | Global service enable |
| tbl_ptr | input | PTR_W | Vector table pointer (base = pointer << 8) |
| mem_addr | output | PTR_W+8 | Vector slot address |
| mem_rd | output | 1 | Read strobe for the vector slot |
| mem_rdata | input | PTR_W+8 | Slot contents, valid one cycle after the strobe |
| vec_addr | output | PTR_W+8 | Handler start address handed to the CPU |
| vec_id | output | 3 | Slot offset of the serviced source |
| vec_valid | output | 1 | One-cycle acknowledge qualifying vec_addr and vec_id |

## Verification
The hardest situation to reach is a priority contest, where several flags are pending at the same moment and must drain in offset order. The stimulus holds `glob_en` low, raises edge requests on two external lines and an internal event, and confirms that no strobe appears while enable is low. It then raises the enable and lets the scoreboard check the order. The level-mode repeat behaviour is a second hard case, because the number of services depends on how long the line is held. The monitor therefore accepts any number of services of that one source, and still checks each address, while the line is held low.

// File: rtl/rvic_pkg.sv
package rvic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CAPT,
        ST_DONE
    } fetch_st_t;
endpackage

// File: rtl/rvic_sense.sv
// Per-line synchroniser and level/edge request detection.
module rvic_sense #(
    parameter int NEXT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] req_n,
    input  logic            edge_mode,
    output logic [NEXT-1:0] hit
);
    for (genvar g = 0; g < NEXT; g++) begin : g_line
        logic [1:0] sync_q;   // synchroniser, idles high
        logic [1:0] act_h;    // history of active samples
        logic       act;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= 2'b11;
                act_h  <= 2'b00;
            end else begin
                sync_q <= {sync_q[0], req_n[g]};
                act_h  <= {act_h[0], act};
            end
        end

        assign act = ~sync_q[1];
        // edge: inactive, then two consecutive active samples
        assign hit[g] = edge_mode ? (act & act_h[0] & ~act_h[1]) : act;
    end
endmodule

// File: rtl/rvic_pend.sv
// Pending flag register with lowest-index-first selection.
module rvic_pend #(
    parameter int NSRC = 5,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic            clr_en,
    input  logic [ID_W-1:0] clr_idx,
    output logic            any,
    output logic [ID_W-1:0] top_idx
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set;
    end

    always_comb begin
        top_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_q[i]) top_idx = ID_W'(i);
        end
    end

    assign any = |pend_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R9: a flag is kept until its own clear
        p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !(clr_en && clr_idx == ID_W'(g))) |=> pend_q[g]);
        // R10: the cleared flag drops unless it is re-raised
        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_idx == ID_W'(g) && !set[g]) |=> !pend_q[g]);
    end
endmodule

// File: rtl/rvic_top.sv
module rvic_top #(
    parameter int PTR_W   = 16,
    parameter int NUM_INT = 1,
    localparam int NEXT   = 4,
    localparam int NSRC   = NEXT + NUM_INT,
    localparam int ID_W   = $clog2(NSRC + 1),
    localparam int ADDR_W = PTR_W + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NEXT-1:0]    ext_req_n,
    input  logic [NUM_INT-1:0] int_evt,
    input  logic               edge_mode,
    input  logic               glob_en,
    input  logic [PTR_W-1:0]   tbl_ptr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    input  logic [ADDR_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [ID_W-1:0]    vec_id,
    output logic               vec_valid
);
    import rvic_pkg::*;

    fetch_st_t         st_q, st_d;
    logic [NEXT-1:0]   ext_hit;
    logic              any_pend;
    logic [ID_W-1:0]   top_idx, sel_q;
    logic [ADDR_W-1:0] addr_q, data_q;
    logic              clr_en;

    rvic_sense #(.NEXT(NEXT)) u_sense (
        .clk(clk), .rst_n(rst_n), .req_n(ext_req_n),
        .edge_mode(edge_mode), .hit(ext_hit)
    );

    rvic_pend #(.NSRC(NSRC), .ID_W(ID_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set({int_evt, ext_hit}),
        .clr_en(clr_en), .clr_idx(sel_q),
        .any(any_pend), .top_idx(top_idx)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sel_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && st_d == ST_FETCH) begin
                sel_q  <= top_idx;
                addr_q <= {tbl_ptr, 8'h00} + ADDR_W'(top_idx) + ADDR_W'(1);
            end
            if (st_q == ST_CAPT) data_q <= mem_rdata;
        end
    end

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        mem_rd    = 1'b0;
        clr_en    = 1'b0;
        vec_valid = 1'b0;
        unique case (st_q)
            ST_IDLE:  if (glob_en && any_pend) st_d = ST_FETCH;
            ST_FETCH: begin mem_rd = 1'b1;    st_d = ST_CAPT; end
            ST_CAPT:  begin clr_en = 1'b1;    st_d = ST_DONE; end
            ST_DONE:  begin vec_valid = 1'b1; st_d = ST_IDLE; end
            default:  st_d = ST_IDLE;
        endcase
    end

    assign mem_addr = addr_q;
    assign vec_addr = data_q;
    assign vec_id   = sel_q + ID_W'(1);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!mem_rd && !vec_valid));
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    p_valid_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(mem_rd, 2));
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && st_q == ST_IDLE) |=> !mem_rd);
    p_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $stable(tbl_ptr)) |-> (mem_addr[ADDR_W-1:8] == tbl_ptr
            && mem_addr[7:0] >= 8'd1 && mem_addr[7:0] <= 8'(NSRC)));
endmodule

// File: tb/rvic_top_tb_top.sv
module rvic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_req_n = 4'hF;
    logic [0:0]  int_evt = 1'b0;
    logic        edge_mode = 1'b0;
    logic        glob_en = 1'b0;
    logic [15:0] tbl_ptr = 16'h0012;
    logic [23:0] mem_addr, mem_rdata, vec_addr;
    logic        mem_rd, vec_valid;
    logic [2:0]  vec_id;

    int checks = 0, errors = 0;
    int svc_cnt = 0, rd_cnt = 0, lenient_cnt = 0;
    int lenient_id = 0;
    logic [23:0] last_rd_addr = '0;
    logic        prev_rd = 1'b0;
    logic [2:0]  exp_q[$];
    bit          done = 0;

    always #10 clk = ~clk;   // 50 MHz

    rvic_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .int_evt(int_evt),
        .edge_mode(edge_mode), .glob_en(glob_en), .tbl_ptr(tbl_ptr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .vec_addr(vec_addr), .vec_id(vec_id), .vec_valid(vec_valid)
    );

    function automatic logic [23:0] hfun(input logic [23:0] a);
        return a * 24'd3 + 24'h000101;
    endfunction

    // memory model: data one cycle after the strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= hfun(mem_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) if (rst_n) begin
        if (mem_rd) begin
            rd_cnt++;
            last_rd_addr = mem_addr;
            check(!prev_rd, "R10 strobe width", 1, 0);
        end
        prev_rd = mem_rd;
        if (vec_valid) begin
            svc_cnt++;
            check(last_rd_addr == ({tbl_ptr, 8'h00} + 24'(vec_id)), "R6 slot address",
                  int'(last_rd_addr), int'({tbl_ptr, 8'h00} + 24'(vec_id)));
            check(vec_addr == hfun(last_rd_addr), "R7 handler word",
                  int'(vec_addr), int'(hfun(last_rd_addr)));
            if (exp_q.size() == 0) begin
                if (lenient_id != 0 && int'(vec_id) == lenient_id) lenient_cnt++;
                else check(0, "R5/R8 unexpected service", int'(vec_id), 0);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                check(vec_id == e, "R8 service order", int'(vec_id), int'(e));
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext(input int k, input int len);
        ext_req_n[k] = 1'b0;
        cyc(len);
        ext_req_n[k] = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int s0, r0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        check(!mem_rd && !vec_valid, "R1 reset outputs", {mem_rd, vec_valid}, 0);
        glob_en = 1'b1;
        cyc(10);
        check(rd_cnt == 0 && svc_cnt == 0, "R1 idle without requests", rd_cnt, 0);

        // R2 / R3: level mode, INT0 held low -> repeated services
        edge_mode = 1'b0;
        lenient_id = 1;
        ext_req_n[0] = 1'b0;
        for (int i = 0; i < 200 && lenient_cnt < 3; i++) cyc(1);
        ext_req_n[0] = 1'b1;
        cyc(20);
        lenient_id = 0;
        check(lenient_cnt >= 1, "R2 level request serviced", lenient_cnt, 1);
        check(lenient_cnt >= 3, "R3 level repeat", lenient_cnt, 3);

        // R4: edge mode, one-cycle low pulse ignored
        edge_mode = 1'b1;
        cyc(5);
        s0 = svc_cnt; r0 = rd_cnt;
        pulse_ext(2, 1);
        cyc(30);
        check(svc_cnt == s0 && rd_cnt == r0, "R4 short pulse ignored", svc_cnt - s0, 0);

        // R5: edge mode, long hold -> exactly one service
        s0 = svc_cnt;
        exp_q.push_back(3'd3);
        pulse_ext(2, 60);
        cyc(30);
        check(svc_cnt - s0 == 1, "R5 one service per edge", svc_cnt - s0, 1);

        // R6: each external line in edge mode
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back(3'(k + 1));
            pulse_ext(k, 3);
            cyc(20);
        end
        check(exp_q.size() == 0, "R6 all lines serviced", exp_q.size(), 0);

        // R6: relocation, internal event at pointer 100h
        tbl_ptr = 16'h0100;
        cyc(2);
        exp_q.push_back(3'd5);
        int_evt = 1'b1;
        cyc(1);
        int_evt = 1'b0;
        cyc(15);
        check(last_rd_addr == 24'h010005, "R6 relocated slot", int'(last_rd_addr), 'h10005);

        // R9 / R8: gated, three pending, then released
        glob_en = 1'b0;
        r0 = rd_cnt;
        pulse_ext(3, 3);
        int_evt = 1'b1;
        cyc(1);
        int_evt = 1'b0;
        pulse_ext(1, 3);
        cyc(30);
        check(rd_cnt == r0, "R9 no fetch while disabled", rd_cnt - r0, 0);
        exp_q.push_back(3'd2);
        exp_q.push_back(3'd4);
        exp_q.push_back(3'd5);
        glob_en = 1'b1;
        cyc(60);
        check(exp_q.size() == 0, "R9 pending kept and serviced", exp_q.size(), 0);
        check(rd_cnt == svc_cnt, "R10 one strobe per service", rd_cnt, svc_cnt);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule